// File: doc/BRIEF.md
# Sectioned Multi-Tap Shift Register

The block holds four single-bit shift sections that run from one shared clock. Sections 0 and 2 have four stages each. Sections 1 and 3 have five stages each, and each also brings out the bit held in its fourth stage as a tap. Every stage moves one place forward on the falling edge of the clock. A register clocked on the rising edge copies the last stage of section 0, so that output lags the normal one by half a clock period. Its purpose is to make cascading into a following register safe when clock edges are slow.

A 3-bit chain select sets how the sections feed one another, so that one serial path can be built with a length between 4 and 18 stages. Any section that is not part of the chain keeps taking its own serial input. With the chain select at zero the four sections are independent. Nothing is stored apart from the stages and the half-cycle register, and a stage keeps its bit for as long as the clock does not fall.

Top module: `sectionShiftReg`

## Requirements
- R1: With chainSel = 0, each section takes its own input bit. serIn[0] feeds section 0, serIn[1] feeds section 1, serIn[2] feeds section 2 and serIn[3] feeds section 3. outA and outC show their input bit from 4 falling edges earlier, outBTap and outDTap from 4 edges earlier, and outB and outD from 5 edges earlier.
- R2: Stages change only on a falling clock edge. Across a rising edge every stage output (outA, outBTap, outB, outC, outDTap, outD) keeps its value.
- R3: When rst is high at a falling edge, every stage is cleared to 0 at that edge. The half-cycle output is cleared at the next rising edge while rst is still high.
- R4: On each rising edge outAHalf loads the current outA. Between a falling edge and the next rising edge it still shows the outA value from before that falling edge.
- R5: chainSel = 1 links section 0 into section 1 and section 2 into section 3. outBTap and outB give serIn[0] delayed by 8 and 9 edges. outDTap and outD give serIn[2] delayed by 8 and 9 edges.
- R6: chainSel = 2 feeds the end of section 1 into section 3. outDTap and outD give serIn[1] delayed by 9 and 10 edges.
- R7: chainSel = 3 links section 0, then the tap of section 1, then section 2. outC gives serIn[0] delayed by 12 edges.
- R8: chainSel = 4 links section 0, then the end of section 1, then section 2. outC gives serIn[0] delayed by 13 edges.
- R9: chainSel = 5 links section 1, then section 2, then section 3. outDTap and outD give serIn[1] delayed by 13 and 14 edges.
- R10: chainSel = 6 links section 0, then the tap of section 1, then sections 2 and 3. outDTap and outD give serIn[0] delayed by 16 and 17 edges.
- R11: chainSel = 7 links section 0, then the end of section 1, then sections 2 and 3. outDTap and outD give serIn[0] delayed by 17 and 18 edges.
- R12: A section that is not linked into the chain keeps its own serIn bit. The serIn bit of a linked section has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; shifting happens on the falling edge |
| rst | input | 1 | Synchronous active-high clear |
| chainSel | input | 3 | Selects how the sections are linked |
| serIn | input | 4 | Serial input, one bit per section |
| outA | output | 1 | Last stage of section 0 |
| outAHalf | output | 1 | outA delayed by half a clock period |
| outBTap | output | 1 | Fourth stage of section 1 |
| outB | output | 1 | Last stage of section 1 |
| outC | output | 1 | Last stage of section 2 |
| outDTap | output | 1 | Fourth stage of section 3 |
| outD | output | 1 | Last stage of section 3 |

## Verification
The link assertions assume that chainSel does not change between two falling edges in which the chain is in use. The stage-advance checks assume that rst changes only while the clock is high. To stay within these limits, the stimulus changes serIn, chainSel and rst just after a rising edge. chainSel changes only while reset is held, so every link property compares neighbours that were joined under the same setting.

// File: rtl/chain_pkg.sv
package chain_pkg;

  localparam int SECT_COUNT = 4;

  typedef enum logic [2:0] {
    CH_SPLIT  = 3'd0,
    CH_PAIRS  = 3'd1,
    CH_BD10   = 3'd2,
    CH_TAP12  = 3'd3,
    CH_FULL13 = 3'd4,
    CH_BCD14  = 3'd5,
    CH_TAP17  = 3'd6,
    CH_FULL18 = 3'd7
  } chainMode_e;

  typedef struct packed {
    logic bFromA;
    logic cFromBTap;
    logic cFromBEnd;
    logic dFromC;
    logic dFromB;
    logic clrStages;
  } linkStrobes_t;

endpackage

// File: rtl/shiftSection.sv
module shiftSection #(
  parameter int STAGES = 4,
  parameter int TAP_AT = 4
) (
  input  logic clk,
  input  logic clr,
  input  logic serialIn,
  output logic headQ,
  output logic tapQ,
  output logic lastQ
);

  logic [STAGES-1:0] stg;
  logic armed;

  always_ff @(negedge clk) begin
    if (clr) stg <= '0;
    else     stg <= {stg[STAGES-2:0], serialIn};
  end

  assign headQ = stg[0];
  assign tapQ  = stg[TAP_AT-1];
  assign lastQ = stg[STAGES-1];

  always_ff @(negedge clk) armed <= !clr;

  AST_HEAD_CAPTURE: assert property (@(negedge clk) disable iff (clr)
    armed |-> stg[0] == $past(serialIn)); // R2

  for (genvar i = 1; i < STAGES; i++) begin : g_adv
    AST_STAGE_ADVANCE: assert property (@(negedge clk) disable iff (clr)
      armed |-> stg[i] == $past(stg[i-1])); // R2
  end

  AST_RESET_CLEARS: assert property (@(negedge clk) disable iff (clr)
    $past(clr) |-> stg == '0); // R3

endmodule

// File: rtl/chainControl.sv
module chainControl
  import chain_pkg::*;
(
  input  logic         rst,
  input  logic [2:0]   chainSel,
  output linkStrobes_t strobes
);

  chainMode_e mode;

  always_comb begin
    mode = chainMode_e'(chainSel);
    strobes = '0;
    strobes.clrStages = rst;
    unique case (mode)
      CH_SPLIT: ;
      CH_PAIRS: begin
        strobes.bFromA = 1'b1;
        strobes.dFromC = 1'b1;
      end
      CH_BD10:   strobes.dFromB = 1'b1;
      CH_TAP12: begin
        strobes.bFromA    = 1'b1;
        strobes.cFromBTap = 1'b1;
      end
      CH_FULL13: begin
        strobes.bFromA    = 1'b1;
        strobes.cFromBEnd = 1'b1;
      end
      CH_BCD14: begin
        strobes.cFromBEnd = 1'b1;
        strobes.dFromC    = 1'b1;
      end
      CH_TAP17: begin
        strobes.bFromA    = 1'b1;
        strobes.cFromBTap = 1'b1;
        strobes.dFromC    = 1'b1;
      end
      CH_FULL18: begin
        strobes.bFromA    = 1'b1;
        strobes.cFromBEnd = 1'b1;
        strobes.dFromC    = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/shiftDatapath.sv
module shiftDatapath
  import chain_pkg::*;
#(
  parameter int SHORT_LEN = 4,
  parameter int LONG_LEN  = 5,
  parameter int TAP_AT    = 4
) (
  input  logic                  clk,
  input  linkStrobes_t          strobes,
  input  logic [SECT_COUNT-1:0] serIn,
  output logic [SECT_COUNT-1:0] tapQ,
  output logic [SECT_COUNT-1:0] lastQ,
  output logic                  halfQ
);

  logic [SECT_COUNT-1:0] feed;
  logic [SECT_COUNT-1:0] headQ;
  logic clr;

  assign clr = strobes.clrStages;

  always_comb begin
    feed[0] = serIn[0];
    feed[1] = strobes.bFromA ? lastQ[0] : serIn[1];
    if (strobes.cFromBTap)      feed[2] = tapQ[1];
    else if (strobes.cFromBEnd) feed[2] = lastQ[1];
    else                        feed[2] = serIn[2];
    if (strobes.dFromC)         feed[3] = lastQ[2];
    else if (strobes.dFromB)    feed[3] = lastQ[1];
    else                        feed[3] = serIn[3];
  end

  for (genvar k = 0; k < SECT_COUNT; k++) begin : g_sect
    localparam int LEN = (k % 2 == 0) ? SHORT_LEN : LONG_LEN;
    shiftSection #(.STAGES(LEN), .TAP_AT(TAP_AT)) u_sect (
      .clk(clk),
      .clr(clr),
      .serialIn(feed[k]),
      .headQ(headQ[k]),
      .tapQ(tapQ[k]),
      .lastQ(lastQ[k])
    );
  end

  always_ff @(posedge clk) begin
    if (clr) halfQ <= 1'b0;
    else     halfQ <= lastQ[0];
  end

  logic posArmed, negArmed;
  always_ff @(posedge clk) posArmed <= !clr;
  always_ff @(negedge clk) negArmed <= !clr;

  AST_HALF_LAGS: assert property (@(posedge clk) disable iff (clr)
    posArmed |-> halfQ == $past(lastQ[0])); // R4

  AST_LINK_A_TO_B: assert property (@(negedge clk) disable iff (clr)
    negArmed && $past(strobes.bFromA) |-> headQ[1] == $past(lastQ[0])); // R5

  AST_LINK_B_TO_D: assert property (@(negedge clk) disable iff (clr)
    negArmed && $past(strobes.dFromB) |-> headQ[3] == $past(lastQ[1])); // R6

  AST_LINK_BTAP_TO_C: assert property (@(negedge clk) disable iff (clr)
    negArmed && $past(strobes.cFromBTap) |-> headQ[2] == $past(tapQ[1])); // R7

  AST_LINK_BEND_TO_C: assert property (@(negedge clk) disable iff (clr)
    negArmed && $past(strobes.cFromBEnd) |-> headQ[2] == $past(lastQ[1])); // R8

  AST_LINK_C_TO_D: assert property (@(negedge clk) disable iff (clr)
    negArmed && $past(strobes.dFromC) |-> headQ[3] == $past(lastQ[2])); // R9

  AST_OWN_INPUT_A: assert property (@(negedge clk) disable iff (clr)
    negArmed |-> headQ[0] == $past(serIn[0])); // R12

endmodule

// File: rtl/sectionShiftReg.sv
module sectionShiftReg
  import chain_pkg::*;
#(
  parameter int SHORT_LEN = 4,
  parameter int LONG_LEN  = 5,
  parameter int TAP_AT    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] chainSel,
  input  logic [3:0] serIn,
  output logic       outA,
  output logic       outAHalf,
  output logic       outBTap,
  output logic       outB,
  output logic       outC,
  output logic       outDTap,
  output logic       outD
);

  linkStrobes_t strobes;
  logic [SECT_COUNT-1:0] tapQ;
  logic [SECT_COUNT-1:0] lastQ;

  chainControl u_ctrl (
    .rst(rst),
    .chainSel(chainSel),
    .strobes(strobes)
  );

  shiftDatapath #(
    .SHORT_LEN(SHORT_LEN),
    .LONG_LEN(LONG_LEN),
    .TAP_AT(TAP_AT)
  ) u_dp (
    .clk(clk),
    .strobes(strobes),
    .serIn(serIn),
    .tapQ(tapQ),
    .lastQ(lastQ),
    .halfQ(outAHalf)
  );

  assign outA    = lastQ[0];
  assign outBTap = tapQ[1];
  assign outB    = lastQ[1];
  assign outC    = lastQ[2];
  assign outDTap = tapQ[3];
  assign outD    = lastQ[3];

endmodule

// File: tb/tb_sectionShiftReg.sv
module tb_sectionShiftReg;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1;
  logic [2:0] chainSel = 3'd0;
  logic [3:0] serIn = 4'd0;
  logic outA, outAHalf, outBTap, outB, outC, outDTap, outD;

  sectionShiftReg dut (
    .clk(clk), .rst(rst), .chainSel(chainSel), .serIn(serIn),
    .outA(outA), .outAHalf(outAHalf), .outBTap(outBTap), .outB(outB),
    .outC(outC), .outDTap(outDTap), .outD(outD)
  );

  typedef struct packed {
    logic [2:0] outSel;
    logic [1:0] src;
    logic [4:0] len;
    logic [3:0] req;
  } probe_t;

  typedef struct packed {
    logic [2:0]       mode;
    probe_t [5:0]     probes;
  } row_t;

  localparam probe_t NONE = '{3'd0, 2'd0, 5'd0, 4'd0};

  // outSel: 0 outA, 1 outBTap, 2 outB, 3 outC, 4 outDTap, 5 outD
  localparam row_t ROWS [8] = '{
    '{3'd0, '{'{3'd0,2'd0,5'd4,4'd1}, '{3'd1,2'd1,5'd4,4'd1}, '{3'd2,2'd1,5'd5,4'd1},   // R1
              '{3'd3,2'd2,5'd4,4'd1}, '{3'd4,2'd3,5'd4,4'd1}, '{3'd5,2'd3,5'd5,4'd1}}},
    '{3'd1, '{'{3'd1,2'd0,5'd8,4'd5}, '{3'd2,2'd0,5'd9,4'd5}, '{3'd4,2'd2,5'd8,4'd5},   // R5
              '{3'd5,2'd2,5'd9,4'd5}, '{3'd0,2'd0,5'd4,4'd12}, '{3'd3,2'd2,5'd4,4'd12}}}, // R12
    '{3'd2, '{'{3'd4,2'd1,5'd9,4'd6}, '{3'd5,2'd1,5'd10,4'd6}, '{3'd0,2'd0,5'd4,4'd12}, // R6
              '{3'd3,2'd2,5'd4,4'd12}, '{3'd2,2'd1,5'd5,4'd12}, NONE}},
    '{3'd3, '{'{3'd3,2'd0,5'd12,4'd7}, '{3'd4,2'd3,5'd4,4'd12}, '{3'd5,2'd3,5'd5,4'd12}, // R7
              '{3'd1,2'd0,5'd8,4'd7}, NONE, NONE}},
    '{3'd4, '{'{3'd3,2'd0,5'd13,4'd8}, '{3'd2,2'd0,5'd9,4'd8}, '{3'd4,2'd3,5'd4,4'd12}, // R8
              '{3'd5,2'd3,5'd5,4'd12}, NONE, NONE}},
    '{3'd5, '{'{3'd5,2'd1,5'd14,4'd9}, '{3'd4,2'd1,5'd13,4'd9}, '{3'd3,2'd1,5'd9,4'd9}, // R9
              '{3'd0,2'd0,5'd4,4'd12}, NONE, NONE}},
    '{3'd6, '{'{3'd4,2'd0,5'd16,4'd10}, '{3'd5,2'd0,5'd17,4'd10}, '{3'd3,2'd0,5'd12,4'd10}, // R10
              NONE, NONE, NONE}},
    '{3'd7, '{'{3'd4,2'd0,5'd17,4'd11}, '{3'd5,2'd0,5'd18,4'd11}, '{3'd3,2'd0,5'd13,4'd11}, // R11
              NONE, NONE, NONE}}
  };

  int checks = 0;
  int errors = 0;
  logic [31:0] hist [4];
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic pick(input logic [2:0] s);
    case (s)
      3'd0: return outA;
      3'd1: return outBTap;
      3'd2: return outB;
      3'd3: return outC;
      3'd4: return outDTap;
      default: return outD;
    endcase
  endfunction

  function automatic logic [5:0] stageOuts();
    return {outA, outBTap, outB, outC, outDTap, outD};
  endfunction

  task automatic nextBits();
    repeat (4) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    serIn = lfsr[3:0];
  endtask

  // Entered and left just after a rising edge.
  task automatic doReset(input logic [2:0] mode);
    rst = 1'b1;
    chainSel = mode;
    serIn = 4'd0;
    repeat (2) @(negedge clk);
    @(posedge clk);
    #1;
    rst = 1'b0;
    for (int i = 0; i < 4; i++) hist[i] = '0;
  endtask

  task automatic step(input row_t r);
    logic [5:0] snap;
    nextBits();
    @(negedge clk);
    for (int i = 0; i < 4; i++) hist[i] = {hist[i][30:0], serIn[i]};
    #2;
    for (int p = 0; p < 6; p++) begin
      if (r.probes[p].len != 0)
        check($sformatf("R%0d mode%0d sel%0d", r.probes[p].req, r.mode, r.probes[p].outSel),
              {5'd0, pick(r.probes[p].outSel)},
              {5'd0, hist[r.probes[p].src][r.probes[p].len - 1]});
    end
    check("R4 half before rise", {5'd0, outAHalf}, {5'd0, hist[0][4]});
    snap = stageOuts();
    @(posedge clk);
    #1;
    check("R2 hold across rise", stageOuts(), snap);
    check("R4 half after rise", {5'd0, outAHalf}, {5'd0, hist[0][3]});
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(posedge clk);
    #1;
    doReset(3'd0);
    // R3: reset state
    check("R3 reset outputs", stageOuts(), 6'd0);
    check("R3 reset half", {5'd0, outAHalf}, 6'd0);

    for (int r = 0; r < 8; r++) begin
      doReset(ROWS[r].mode);
      for (int s = 0; s < 40; s++) step(ROWS[r]);
    end

    // R3 directed: fill with ones, then reset
    doReset(3'd7);
    serIn = 4'hF;
    repeat (20) begin
      @(negedge clk);
      @(posedge clk);
      #1;
    end
    check("R3 filled before reset", stageOuts(), 6'h3F);
    rst = 1'b1;
    @(negedge clk);
    #2;
    check("R3 cleared at fall", stageOuts(), 6'd0);
    check("R4 half unchanged until rise", {5'd0, outAHalf}, 6'd1);
    @(posedge clk);
    #1;
    check("R3 half cleared at rise", {5'd0, outAHalf}, 6'd0);
    rst = 1'b0;

    // R12 directed: in mode 1 a constant serIn[1] must not reach outB
    doReset(3'd1);
    serIn = 4'b0010;
    repeat (12) begin
      @(negedge clk);
      @(posedge clk);
      #1;
    end
    check("R12 linked input ignored", {4'd0, outBTap, outB}, 6'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule